// File: doc/BRIEF.md
# Parallel MPU Display Write Controller

This block is the write side of a parallel, microprocessor-style display bus. A client hands it one 16-bit word at a time over a valid/ready port, together with a flag marking the word as a command or as pixel/parameter data. The block then plays out one complete bus write: it first presents the command/data select line, asserts chip select after a programmable setup delay, drives the write strobe, keeps the word on the bus for a programmable hold time, releases chip select and keeps the command/data line steady for a final programmable interval before it accepts the next word.

Two bus conventions are supported, chosen per transfer by a protocol input. In the 8080 convention an active-low write strobe marks the data setup interval. In the 6800 convention a read/write line stays low for the whole transfer and an active-high enable marks the data setup interval. Four 8-bit timing inputs (command setup, data setup, data hold, command hold) set every interval in whole cycles of the display clock that runs the block.

Top module: `mpu_wr_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, chip select is high, the write strobe is high, enable is low, read/write is high, the bus drive enable is low, the data bus reads zero and the request port is ready.
- R2: The port is ready only when idle. A word is taken on a clock edge where valid and ready are both high. Ready goes low in the cycle after that edge and returns high one cycle after the command hold interval ends. Words offered while busy are ignored.
- R3: After a word is taken, the block spends C cycles in command setup with chip select high, then D+H cycles with chip select low, then K cycles in command hold with chip select high. C, D, H and K are the effective command setup, data setup, data hold and command hold counts.
- R4: The effective count of each timing field equals the field value, except that a value of zero counts as one cycle.
- R5: The command/data line is low for a command word (flag 1) and high for a data word (flag 0). It keeps its value from the start of command setup through the end of command hold.
- R6: With the protocol input at 0 (8080), the write strobe is low exactly during the first D cycles of chip select. Enable stays low and read/write stays high.
- R7: With the protocol input at 1 (6800), read/write is low from the start of command setup through the end of command hold. Enable is high exactly during the first D cycles of chip select. The write strobe stays high.
- R8: The bus drive enable is high and the data bus carries the accepted word from the start of command setup through the end of data hold. At every other time the bus drive enable is low and the data bus reads zero.
- R9: The protocol input and the four timing fields are sampled only on the edge where a word is taken. Changing them during a transfer has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock; all intervals count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| proto_6800 | input | 1 | 0 = 8080 convention, 1 = 6800 convention |
| tim_cmd_setup | input | 8 | Command setup count |
| tim_cmd_hold | input | 8 | Command hold count |
| tim_dat_setup | input | 8 | Data setup count |
| tim_dat_hold | input | 8 | Data hold count |
| req_valid | input | 1 | Word offered |
| req_ready | output | 1 | Block is idle and will take a word |
| req_is_cmd | input | 1 | 1 = command word, 0 = data word |
| req_data | input | 16 | Word to write |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_dc | output | 1 | Command/data select, low for command |
| bus_wr_n | output | 1 | 8080 write strobe, active low |
| bus_en | output | 1 | 6800 enable, active high |
| bus_rw | output | 1 | 6800 read/write, low for write |
| bus_data | output | 16 | Parallel data bus |
| bus_data_oe | output | 1 | Drive enable for the data bus |

## Verification
The bound checker watches on every cycle that chip select stays low for exactly the latched data setup plus data hold count, that the strobe and enable only pulse inside chip select and never together, that the bus is driven whenever chip select is active, that the command/data line stays steady under chip select, and that a taken word drops ready. Only the bench's scenarios can show the whole timeline: the length of the command setup and hold intervals, the zero-counts-as-one rule, the exact word on the bus, and that protocol or timing changes and extra requests offered mid-transfer are ignored. The bench compares every output in every cycle of each transfer against a model built from the four counts.

// File: rtl/mpu_wr_ctrl.sv
module mpu_wr_ctrl #(
  parameter int DW = 16,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          proto_6800,
  input  logic [TW-1:0] tim_cmd_setup,
  input  logic [TW-1:0] tim_cmd_hold,
  input  logic [TW-1:0] tim_dat_setup,
  input  logic [TW-1:0] tim_dat_hold,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_is_cmd,
  input  logic [DW-1:0] req_data,
  output logic          bus_cs_n,
  output logic          bus_dc,
  output logic          bus_wr_n,
  output logic          bus_en,
  output logic          bus_rw,
  output logic [DW-1:0] bus_data,
  output logic          bus_data_oe
);

  typedef enum logic [2:0] {S_IDLE, S_CSU, S_DSU, S_DHO, S_CHO} phase_t;

  phase_t        ph;
  logic [TW-1:0] cnt;
  logic [TW-1:0] t_ch, t_ds, t_dh;
  logic          m6800;
  logic          cmd_q;
  logic [DW-1:0] word_q;
  logic          take;
  logic          cs_on;

  function automatic logic [TW-1:0] last_cnt(input logic [TW-1:0] v);
    return (v == '0) ? '0 : v - TW'(1);
  endfunction

  assign take = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= S_IDLE;
      cnt    <= '0;
      t_ch   <= '0;
      t_ds   <= '0;
      t_dh   <= '0;
      m6800  <= 1'b0;
      cmd_q  <= 1'b0;
      word_q <= '0;
    end else if (ph == S_IDLE) begin
      if (take) begin
        ph     <= S_CSU;
        cnt    <= last_cnt(tim_cmd_setup);
        t_ch   <= tim_cmd_hold;
        t_ds   <= tim_dat_setup;
        t_dh   <= tim_dat_hold;
        m6800  <= proto_6800;
        cmd_q  <= req_is_cmd;
        word_q <= req_data;
      end
    end else if (cnt != '0) begin
      cnt <= cnt - TW'(1);
    end else begin
      case (ph)
        S_CSU:   begin ph <= S_DSU; cnt <= last_cnt(t_ds); end
        S_DSU:   begin ph <= S_DHO; cnt <= last_cnt(t_dh); end
        S_DHO:   begin ph <= S_CHO; cnt <= last_cnt(t_ch); end
        default: ph <= S_IDLE;
      endcase
    end
  end

  assign cs_on       = (ph == S_DSU) || (ph == S_DHO);
  assign req_ready   = (ph == S_IDLE);
  assign bus_cs_n    = !cs_on;
  assign bus_dc      = !cmd_q;
  assign bus_wr_n    = !(!m6800 && ph == S_DSU);
  assign bus_en      = m6800 && ph == S_DSU;
  assign bus_rw      = !(m6800 && ph != S_IDLE);
  assign bus_data_oe = cs_on || (ph == S_CSU);
  assign bus_data    = bus_data_oe ? word_q : '0;

endmodule

// File: rtl/mpu_wr_ctrl_chk.sv
module mpu_wr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] tim_dat_setup,
  input logic [7:0] tim_dat_hold,
  input logic       req_valid,
  input logic       req_ready,
  input logic       bus_cs_n,
  input logic       bus_dc,
  input logic       bus_wr_n,
  input logic       bus_en,
  input logic       bus_rw,
  input logic       bus_data_oe
);

  logic [9:0] lo_run;
  logic [9:0] want_w;

  function automatic logic [9:0] at_least1(input logic [7:0] v);
    return (v == 8'd0) ? 10'd1 : {2'b00, v};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run <= '0;
      want_w <= '0;
    end else begin
      lo_run <= bus_cs_n ? 10'd0 : lo_run + 10'd1;
      if (req_valid && req_ready)
        want_w <= at_least1(tim_dat_setup) + at_least1(tim_dat_hold);
    end
  end

  AST_CS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cs_n) |-> (lo_run == want_w)); // R3
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> !bus_cs_n && !bus_en && bus_rw); // R6
  AST_EN_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |-> !bus_cs_n && !bus_rw && bus_wr_n); // R7
  AST_BUS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cs_n |-> bus_data_oe); // R8
  AST_DC_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && !$past(bus_cs_n)) |-> $stable(bus_dc)); // R5
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> bus_cs_n && !bus_data_oe && bus_rw && !bus_en); // R2

endmodule

bind mpu_wr_ctrl mpu_wr_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n),
  .tim_dat_setup(tim_dat_setup), .tim_dat_hold(tim_dat_hold),
  .req_valid(req_valid), .req_ready(req_ready),
  .bus_cs_n(bus_cs_n), .bus_dc(bus_dc), .bus_wr_n(bus_wr_n),
  .bus_en(bus_en), .bus_rw(bus_rw), .bus_data_oe(bus_data_oe)
);

// File: tb/mpu_wr_ctrl_test.sv
`timescale 1ns/1ps
module mpu_wr_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic proto_6800 = 1'b0;
  logic [7:0] tim_cmd_setup = '0, tim_cmd_hold = '0, tim_dat_setup = '0, tim_dat_hold = '0;
  logic req_valid = 1'b0, req_is_cmd = 1'b0;
  logic [15:0] req_data = '0;
  logic req_ready, bus_cs_n, bus_dc, bus_wr_n, bus_en, bus_rw, bus_data_oe;
  logic [15:0] bus_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpu_wr_ctrl uut (.*);

  function automatic int eff(input logic [7:0] v);
    return (v == 8'd0) ? 1 : int'(v);
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic xfer(input bit m, input bit is_cmd, input logic [15:0] w,
                      input logic [7:0] cs, input logic [7:0] ds,
                      input logic [7:0] dh, input logic [7:0] ch,
                      input bit disturb);
    int c = eff(cs), d = eff(ds), h = eff(dh), k = eff(ch);
    int all = c + d + h + k;
    @(negedge clk);
    chk("R2 ready idle", req_ready, 1);
    proto_6800 = m; req_is_cmd = is_cmd; req_data = w;
    tim_cmd_setup = cs; tim_dat_setup = ds; tim_dat_hold = dh; tim_cmd_hold = ch;
    req_valid = 1'b1;
    for (int n = 1; n <= all + 1; n++) begin
      @(negedge clk);
      if (n == 1 && !disturb) req_valid = 1'b0;
      if (n == 2 && disturb) begin
        proto_6800 = ~m; req_is_cmd = ~is_cmd; req_data = ~w;
        tim_cmd_setup = 8'd9; tim_dat_setup = 8'd7; tim_dat_hold = 8'd5; tim_cmd_hold = 8'd3;
      end
      if (n <= all) begin
        bit cson = (n > c) && (n <= c + d + h);
        bit stb  = (n > c) && (n <= c + d);
        bit oe   = (n <= c + d + h);
        chk("R2 busy", req_ready, 0);
        chk(disturb ? "R9 cs" : "R3 cs", bus_cs_n, !cson);
        chk("R5 dc", bus_dc, !is_cmd);
        chk(m ? "R7 wr" : "R6 wr", bus_wr_n, !(stb && !m));
        chk(m ? "R7 en" : "R6 en", bus_en, stb && m);
        chk(m ? "R7 rw" : "R6 rw", bus_rw, !m);
        chk("R8 oe", bus_data_oe, oe);
        chk(disturb ? "R9 data" : "R8 data", bus_data, oe ? w : 16'h0);
      end else begin
        chk("R2 ready back", req_ready, 1);
        chk("R3 end cs", bus_cs_n, 1);
        chk("R8 end oe", bus_data_oe, 0);
        chk("R8 end data", bus_data, 0);
        chk("R7 end rw", bus_rw, 1);
        req_valid = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    chk("R1 cs", bus_cs_n, 1); chk("R1 wr", bus_wr_n, 1); chk("R1 en", bus_en, 0);
    chk("R1 rw", bus_rw, 1); chk("R1 oe", bus_data_oe, 0); chk("R1 data", bus_data, 0);
    chk("R1 ready", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after", bus_cs_n, 1); chk("R1 ready after", req_ready, 1);
    // R4: all zero fields act as one cycle each
    xfer(1'b0, 1'b1, 16'hA55A, 8'd0, 8'd0, 8'd0, 8'd0, 1'b0);
    xfer(1'b1, 1'b0, 16'h1234, 8'd0, 8'd0, 8'd0, 8'd0, 1'b0);
    // R6 / R7 longer intervals
    xfer(1'b0, 1'b0, 16'hFFFF, 8'd3, 8'd5, 8'd2, 8'd4, 1'b0);
    xfer(1'b1, 1'b1, 16'h0001, 8'd20, 8'd1, 8'd17, 8'd2, 1'b0);
    // R9 and R2: inputs disturbed and request held while busy
    xfer(1'b0, 1'b1, 16'hC3C3, 8'd2, 8'd3, 8'd1, 8'd2, 1'b1);
    xfer(1'b1, 1'b0, 16'h5AA5, 8'd4, 8'd2, 8'd3, 8'd1, 1'b1);
    // no request: block stays idle (R2)
    repeat (5) @(negedge clk);
    chk("R2 idle stays", req_ready, 1); chk("R2 idle cs", bus_cs_n, 1);
    for (int i = 0; i < 60; i++)
      xfer(1'($urandom), 1'($urandom), 16'($urandom),
           8'($urandom % 6), 8'($urandom % 6), 8'($urandom % 6), 8'($urandom % 6),
           1'($urandom % 4 == 0));
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule